// File: doc/BRIEF.md
# Centisecond Real-Time Clock with Periodic Interrupt

This block keeps time in hundredths of a second and whole seconds, and it also produces an interrupt at a programmable interval. A prescaler outside the block supplies a one-cycle tick every 1/100 s. Each tick advances a hundredths counter that runs from 0 to 99. When that counter wraps, it carries into a seconds counter that runs from 0 to 59. The clock never stops. Software can read either counter through an indexed register port, and it can overwrite either one at any time.

The same tick also drives an 8-bit periodic counter. This counter is controlled by a small state machine with three states: `PI_IDLE` (halted, counter held at 0), `PI_RUN` (counting, with an interrupt on each match) and `PI_DRAIN` (counting, with no interrupts). The transitions are:

- **start** (`PI_IDLE`→`PI_RUN`): a non-zero modulus is written.
- **stop** (`PI_RUN`→`PI_DRAIN`): a zero modulus is written.
- **resume** (`PI_DRAIN`→`PI_RUN`): a non-zero modulus is written.
- **park** (`PI_DRAIN`→`PI_IDLE`): a tick arrives while the counter is 255, and no modulus write happens in that cycle.

Index 05H is shared by two registers. A write to 05H sets the modulus, which cannot be read back. A read from 05H returns the counter, which cannot be written.

Top module: `cs_rtc`

## Requirements
- R1: After reset, reads of indices 01H, 02H and 05H return 0, `irq` is low, and the periodic counter is halted.
- R2: Each tick advances the hundredths value. After 99 the value wraps to 0 and the seconds value advances by one. Index 02H returns the hundredths value in bits 6:0, and bit 7 reads 0.
- R3: After 59 the seconds value wraps to 0. Index 01H returns the seconds value in bits 5:0, and bits 7:6 read 0.
- R4: A write to 01H or 02H loads the value on the next edge. Unused upper bits are dropped. A value above the register's maximum loads 0 instead. A tick in the same cycle as the write is discarded by the clock.
- R5: Index 05H returns the periodic counter, which advances by one per tick while running or draining. A write to 05H changes the modulus only, never the counter.
- R6: With modulus M≠0 in `PI_RUN`, the tick that would bring the counter to M instead sets the counter to 0. In the following cycle `irq` is high for one cycle, so interrupts come every M ticks.
- R7: Writing modulus 0 blocks any interrupt from that cycle on. The counter keeps advancing until it rolls over from 255 to 0, and after that it stays at 0 regardless of ticks.
- R8: A non-zero modulus written while draining resumes interrupts without clearing the counter.
- R9: `rdata` is 0 when `rd_en` is low or when the index is not 01H, 02H or 05H.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle pulse every 1/100 s |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 8 | Register index |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data (combinational from `addr`) |
| irq | output | 1 | Periodic interrupt pulse |

## Verification
The clock is tested with a continuous tick for more than 61 seconds of count, which checks every hundredths wrap and one seconds wrap. It is also tested with writes that land on a tick, are out of range, or have upper bits set; these show that loads take priority and that values are clamped. The periodic counter is tested with a tick every cycle and with a tick every third cycle. This separates ticks from clock cycles in both the match timing and the interrupt spacing. A zero-modulus write followed by several hundred ticks shows the counter draining and then parking at 0. A resume issued while draining shows that the counter is not cleared, because the next interrupt comes only after the 8-bit wrap.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
    typedef enum logic [1:0] {
        PI_IDLE  = 2'd0,
        PI_RUN   = 2'd1,
        PI_DRAIN = 2'd2
    } pi_state_e;

    localparam int IDX_SEC = 1;
    localparam int IDX_CS  = 2;
    localparam int IDX_PI  = 5;
endpackage

// File: rtl/rtc_time.sv
module rtc_time #(
    parameter int DATA_W  = 8,
    parameter int CS_MAX  = 99,
    parameter int SEC_MAX = 59,
    localparam int CS_W   = $clog2(CS_MAX + 1),
    localparam int SEC_W  = $clog2(SEC_MAX + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ld_cs,
    input  logic              ld_sec,
    input  logic [DATA_W-1:0] wdata,
    output logic [CS_W-1:0]   cs_q,
    output logic [SEC_W-1:0]  sec_q
);
    localparam logic [CS_W-1:0]  CS_LIM  = CS_W'(CS_MAX);
    localparam logic [SEC_W-1:0] SEC_LIM = SEC_W'(SEC_MAX);

    logic [CS_W-1:0]  cs_load;
    logic [SEC_W-1:0] sec_load;

    // Values above the maximum are replaced by zero.
    assign cs_load  = (wdata[CS_W-1:0]  > CS_LIM)  ? '0 : wdata[CS_W-1:0];
    assign sec_load = (wdata[SEC_W-1:0] > SEC_LIM) ? '0 : wdata[SEC_W-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q  <= '0;
            sec_q <= '0;
        end else if (ld_cs || ld_sec) begin
            // A write wins; a tick in the same cycle is discarded.
            if (ld_cs)  cs_q  <= cs_load;
            if (ld_sec) sec_q <= sec_load;
        end else if (tick) begin
            if (cs_q == CS_LIM) begin
                cs_q  <= '0;
                sec_q <= (sec_q == SEC_LIM) ? '0 : sec_q + 1'b1;
            end else begin
                cs_q <= cs_q + 1'b1;
            end
        end
    end

    p_cs_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cs_q <= CS_LIM);
    p_sec_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sec_q <= SEC_LIM);
    p_cs_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_cs && !ld_sec && cs_q == CS_LIM) |=> (cs_q == '0));
    p_sec_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ld_cs && !ld_sec && cs_q == CS_LIM && sec_q == SEC_LIM) |=> (sec_q == '0));
    p_tick_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ld_sec |=> (cs_q == $past(cs_q)));
endmodule

// File: rtl/rtc_pint.sv
module rtc_pint #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_mod,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic             irq_o
);
    import rtc_pkg::*;

    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    pi_state_e        state_q, state_d;
    logic [CNT_W-1:0] mod_q;
    logic [CNT_W-1:0] cnt_inc;
    logic             zero_wr, hit, drain_end;

    assign cnt_inc   = cnt_q + 1'b1;
    assign zero_wr   = ld_mod && (wdata == '0);
    assign hit       = tick && (state_q == PI_RUN) && !zero_wr && (cnt_inc == mod_q);
    assign drain_end = tick && (state_q == PI_DRAIN) && (cnt_q == CNT_TOP);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PI_IDLE:  if (ld_mod && !zero_wr) state_d = PI_RUN;
            PI_RUN:   if (zero_wr) state_d = PI_DRAIN;
            PI_DRAIN: begin
                if (ld_mod && !zero_wr)      state_d = PI_RUN;
                else if (drain_end && !ld_mod) state_d = PI_IDLE;
            end
            default:  state_d = PI_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PI_IDLE;
        else        state_q <= state_d;
    end

    // Outputs: counter, modulus and interrupt
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mod_q <= '0;
            irq_o <= 1'b0;
        end else begin
            irq_o <= hit;
            if (ld_mod) mod_q <= wdata;
            if (tick && state_q != PI_IDLE) cnt_q <= hit ? '0 : cnt_inc;
        end
    end

    p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PI_IDLE) |-> (cnt_q == '0));
    p_irq_cnt_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (cnt_q == '0));
    p_irq_src_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(state_q) == PI_RUN));
    p_stop_now_r7: assert property (@(posedge clk) disable iff (!rst_n)
        zero_wr |=> !irq_o);
    p_park_r7: assert property (@(posedge clk) disable iff (!rst_n)
        drain_end && !ld_mod |=> (state_q == PI_IDLE));
    p_keep_cnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_mod && !tick) |=> (cnt_q == $past(cnt_q)));
endmodule

// File: rtl/cs_rtc.sv
module cs_rtc #(
    parameter int ADDR_W  = 8,
    parameter int DATA_W  = 8,
    parameter int CS_MAX  = 99,
    parameter int SEC_MAX = 59
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    import rtc_pkg::*;

    localparam int CS_W  = $clog2(CS_MAX + 1);
    localparam int SEC_W = $clog2(SEC_MAX + 1);

    logic              sel_sec, sel_cs, sel_pi;
    logic [CS_W-1:0]   cs_val;
    logic [SEC_W-1:0]  sec_val;
    logic [DATA_W-1:0] pi_cnt;

    assign sel_sec = (addr == ADDR_W'(IDX_SEC));
    assign sel_cs  = (addr == ADDR_W'(IDX_CS));
    assign sel_pi  = (addr == ADDR_W'(IDX_PI));

    rtc_time #(
        .DATA_W (DATA_W),
        .CS_MAX (CS_MAX),
        .SEC_MAX(SEC_MAX)
    ) u_time (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .ld_cs (wr_en && sel_cs),
        .ld_sec(wr_en && sel_sec),
        .wdata (wdata),
        .cs_q  (cs_val),
        .sec_q (sec_val)
    );

    rtc_pint #(
        .CNT_W(DATA_W)
    ) u_pint (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .ld_mod(wr_en && sel_pi),
        .wdata (wdata),
        .cnt_q (pi_cnt),
        .irq_o (irq)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            if (sel_sec)     rdata = DATA_W'(sec_val);
            else if (sel_cs) rdata = DATA_W'(cs_val);
            else if (sel_pi) rdata = pi_cnt;
        end
    end

    p_rd_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));
endmodule

// File: tb/cs_rtc_tb.sv
module cs_rtc_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       irq;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int irq_seen = 0;

    // reference model state
    int m_cs = 0, m_sec = 0, m_cnt = 0, m_mod = 0, m_st = 0;
    bit m_irq = 1'b0;

    always #4 clk = ~clk;

    cs_rtc u_dut (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata),
        .irq  (irq)
    );

    task automatic chk(input string req, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s got=%0d exp=%0d at cycle %0d", req, got, exp, cyc);
        end
    endtask

    // Model update on each edge, compared just after it
    always @(posedge clk) begin
        int  ost;
        int  nx;
        int  v;
        bit  zw;
        int  exp_rd;
        cyc++;
        if (!rst_n) begin
            m_cs = 0; m_sec = 0; m_cnt = 0; m_mod = 0; m_st = 0; m_irq = 1'b0;
        end else begin
            zw = wr_en && addr == 8'h05 && wdata == 8'h00;
            ost = m_st;
            m_irq = 1'b0;
            if (tick && ost != 0) begin
                nx = (m_cnt + 1) % 256;
                if (ost == 1 && !zw && nx == m_mod) begin
                    m_cnt = 0;
                    m_irq = 1'b1;
                end else begin
                    m_cnt = nx;
                end
                if (ost == 2 && nx == 0) m_st = 0;
            end
            if (wr_en && addr == 8'h05) begin
                m_mod = wdata;
                if (wdata != 0) m_st = 1;
                else if (ost != 0) m_st = 2;
            end
            if (wr_en && addr == 8'h02) begin
                v = wdata % 128;
                m_cs = (v > 99) ? 0 : v;
            end else if (wr_en && addr == 8'h01) begin
                v = wdata % 64;
                m_sec = (v > 59) ? 0 : v;
            end else if (tick) begin
                if (m_cs == 99) begin
                    m_cs = 0;
                    m_sec = (m_sec == 59) ? 0 : m_sec + 1;
                end else begin
                    m_cs = m_cs + 1;
                end
            end
        end
        #1;
        if (irq) irq_seen++;
        chk("R6 irq", int'(irq), int'(m_irq));
        exp_rd = 0;
        if (rd_en) begin
            case (addr)
                8'h01:   exp_rd = m_sec;
                8'h02:   exp_rd = m_cs;
                8'h05:   exp_rd = m_cnt;
                default: exp_rd = 0;
            endcase
        end
        case (addr)
            8'h01:   chk("R3 rdata", int'(rdata), exp_rd);
            8'h02:   chk("R2 rdata", int'(rdata), exp_rd);
            8'h05:   chk("R5 rdata", int'(rdata), exp_rd);
            default: chk("R9 rdata", int'(rdata), exp_rd);
        endcase
    end

    // Watchdog
    always @(posedge clk) begin
        if (cyc > 100000) begin
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        addr = a;
        rd_en = 1'b1;
        #1;
        v = int'(rdata);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        addr = a;
        wdata = d;
        wr_en = 1'b1;
        step(1);
        wr_en = 1'b0;
    endtask

    initial begin
        int v;
        int base;
        step(3);
        rst_n = 1'b1;
        // R1: reset values
        rd(8'h01, v); chk("R1 sec", v, 0);
        rd(8'h02, v); chk("R1 cs", v, 0);
        rd(8'h05, v); chk("R1 cnt", v, 0);
        chk("R1 irq", int'(irq), 0);
        step(1);

        // R2/R3: continuous ticks, alternating read index
        rd_en = 1'b1;
        tick = 1'b1;
        for (int k = 0; k < 6100; k++) begin
            addr = ((k / 50) % 2 == 0) ? 8'h02 : 8'h01;
            step(1);
        end
        tick = 1'b0;
        rd(8'h01, v); chk("R3 sec after 6100 ticks", v, 1);
        rd(8'h02, v); chk("R2 cs after 6100 ticks", v, 0);

        // R4: write with a coincident tick; upper bit dropped
        tick = 1'b1;
        wr(8'h02, 8'hE3);
        tick = 1'b0;
        rd(8'h02, v); chk("R4 cs load 99", v, 99);
        wr(8'h02, 8'h7F);
        rd(8'h02, v); chk("R4 cs clamp", v, 0);
        wr(8'h01, 8'hFB);
        rd(8'h01, v); chk("R4 sec load 59", v, 59);
        wr(8'h02, 8'd99);
        tick = 1'b1; step(1); tick = 1'b0;
        rd(8'h01, v); chk("R3 sec wrap", v, 0);
        rd(8'h02, v); chk("R2 cs wrap", v, 0);

        // R5/R6: modulus 4 from a halted counter
        wr(8'h05, 8'd4);
        rd(8'h05, v); chk("R5 write keeps counter", v, 0);
        tick = 1'b1; step(3); tick = 1'b0;
        rd(8'h05, v); chk("R5 count 3", v, 3);
        chk("R6 no irq yet", int'(irq), 0);
        tick = 1'b1; step(1); tick = 1'b0;
        chk("R6 irq on match", int'(irq), 1);
        rd(8'h05, v); chk("R6 counter cleared", v, 0);
        step(1);
        chk("R6 irq one cycle", int'(irq), 0);

        // sparse ticks with modulus 7
        wr(8'h05, 8'd7);
        addr = 8'h05;
        for (int k = 0; k < 90; k++) begin
            tick = (k % 3 == 0);
            step(1);
        end
        tick = 1'b0;

        // R7: stop, drain, park
        wr(8'h05, 8'h00);
        base = irq_seen;
        addr = 8'h05;
        tick = 1'b1; step(300); tick = 1'b0;
        chk("R7 no irq after stop", irq_seen - base, 0);
        rd(8'h05, v); chk("R7 parked at 0", v, 0);
        tick = 1'b1; step(20); tick = 1'b0;
        rd(8'h05, v); chk("R7 stays 0", v, 0);

        // R8: resume during drain keeps the count
        wr(8'h05, 8'd3);
        tick = 1'b1; step(10); tick = 1'b0;
        wr(8'h05, 8'h00);
        tick = 1'b1; step(5); tick = 1'b0;
        rd(8'h05, v); chk("R7 drain counts", v, 6);
        wr(8'h05, 8'd3);
        rd(8'h05, v); chk("R8 resume keeps count", v, 6);
        base = irq_seen;
        tick = 1'b1; step(252); tick = 1'b0;
        chk("R8 no irq before wrap", irq_seen - base, 0);
        tick = 1'b1; step(1); tick = 1'b0;
        chk("R8 irq after wrap", int'(irq), 1);

        // R9: read gating and unknown index
        rd_en = 1'b0; addr = 8'h01; #1;
        chk("R9 rd_en low", int'(rdata), 0);
        rd(8'h03, v); chk("R9 unknown index", v, 0);
        step(2);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule